// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

This block forms the unsigned 32-bit value `mcand * mplier + addend` from three 16-bit operand words. It uses a shift-and-add loop of its own instead of an array multiplier. A one-cycle `start` strobe captures the three operands. The unit then runs its loop and raises `done` for one cycle. From that cycle on, the high and low result words stay valid until the next accepted start.

At the start, the addend is placed in the high result word and the multiplicand in the low word. At each bit step the unit tests the lowest bit of the low word. When that bit is set, it adds the captured multiplier into the high word. The carry bit, the high word and the low word then shift right together as one 33-bit value. Each clock pass performs two such steps, so a 16-bit operand takes eight passes. When the multiplier is zero the loop is skipped, and the answer (high zero, low equal to the addend) appears one cycle after the start. A start that arrives while the loop is running is ignored.

Top module: `mac_seq`

## Requirements
- R1: When `done` is high, `{res_hi, res_lo}` equals the 32-bit unsigned value `mcand * mplier + addend` of the operands captured with the accepted start.
- R2: For a nonzero multiplier, `done` is high in the ninth clock cycle after the cycle in which `start` was accepted, which is one cycle for capture plus eight passes of two bit steps each.
- R3: For a zero multiplier, `done` is high in the first cycle after the start cycle, with `res_hi` = 0 and `res_lo` equal to the addend.
- R4: `done` is a single-cycle pulse, and there is exactly one pulse for each accepted start.
- R5: A `start` asserted while the loop is running changes neither the result nor the time at which `done` appears.
- R6: While the unit is idle and `start` is low, `res_hi` and `res_lo` hold their values, whatever the operand inputs do.
- R7: A synchronous active-high `rst` clears `res_hi` and `res_lo` to 0, drives `done` low and returns the unit to idle.
- R8: Operand extremes are exact, for example 0xFFFF * 0xFFFF + 0xFFFF = 0xFFFF0000 and a zero multiplicand gives `{0, addend}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operand capture strobe, taken only when idle |
| mcand | input | 16 | Multiplicand word |
| mplier | input | 16 | Multiplier word |
| addend | input | 16 | Word added to the product |
| res_hi | output | 16 | Upper half of the result |
| res_lo | output | 16 | Lower half of the result |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong bit in the low word shows at the next test of the lowest bit. It changes whether the multiplier is added and so corrupts the result that `done` presents. A wrong carry shows in the most significant bits of `res_hi`. Operands with all bits set, with single bits set, and random values expose both faults within one operation. A fault in the pass counter shows at the ports as `done` arriving in a cycle other than the ninth after the start. A fault in the accept logic shows as a restarted or altered result when a start is injected mid-loop.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mac_state_t;
endpackage

// File: rtl/mac_bitstep.sv
module mac_bitstep #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] mul_in,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic         add_taken
);
  // One conditional add followed by a right shift of {carry, hi, lo}.
  function automatic logic [W:0] cond_sum(input logic [W-1:0] h,
                                          input logic [W-1:0] m,
                                          input logic         en);
    logic [W:0] addend_ext;
    addend_ext = en ? {1'b0, m} : '0;
    return {1'b0, h} + addend_ext;
  endfunction

  logic [W:0] sum;

  always_comb begin
    sum       = cond_sum(hi_in, mul_in, lo_in[0]);
    add_taken = lo_in[0];
    hi_out    = sum[W:1];
    lo_out    = {sum[0], lo_in[W-1:1]};
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int W     = 16,
  parameter int STEPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_run,
  input  logic         load_zero,
  input  logic         step_en,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic [W-1:0] addend,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [W-1:0] hi_q, lo_q, mul_q;
  logic [W-1:0] hi_chain [STEPS+1];
  logic [W-1:0] lo_chain [STEPS+1];
  logic [STEPS-1:0] add_seen;

  assign hi_chain[0] = hi_q;
  assign lo_chain[0] = lo_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    mac_bitstep #(.W(W)) u_step (
      .hi_in    (hi_chain[g]),
      .lo_in    (lo_chain[g]),
      .mul_in   (mul_q),
      .hi_out   (hi_chain[g+1]),
      .lo_out   (lo_chain[g+1]),
      .add_taken(add_seen[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      mul_q <= '0;
    end else if (load_zero) begin
      hi_q <= '0;
      lo_q <= addend;
    end else if (load_run) begin
      hi_q  <= addend;
      lo_q  <= mcand;
      mul_q <= mplier;
    end else if (step_en) begin
      hi_q <= hi_chain[STEPS];
      lo_q <= lo_chain[STEPS];
    end
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int PASSES = 8,
  localparam int CW = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mul_is_zero,
  output logic load_run,
  output logic load_zero,
  output logic step_en,
  output logic busy,
  output logic last_pass,
  output logic done
);
  mac_state_t state_q;
  logic [CW-1:0] pass_q;
  logic accept;

  assign busy      = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && start;
  assign load_run  = accept && !mul_is_zero;
  assign load_zero = accept && mul_is_zero;
  assign step_en   = busy;
  assign last_pass = busy && (pass_q == CW'(PASSES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_zero) begin
        done <= 1'b1;
      end else if (load_run) begin
        state_q <= ST_RUN;
        pass_q  <= '0;
      end else if (busy) begin
        pass_q <= pass_q + 1'b1;
        if (last_pass) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mac_seq.sv
module mac_seq #(
  parameter int W             = 16,
  parameter int BITS_PER_PASS = 2,
  localparam int PASSES       = W / BITS_PER_PASS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic [W-1:0] addend,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         done
);
  logic load_run, load_zero, step_en, busy, last_pass;
  logic mul_is_zero;

  assign mul_is_zero = (mplier == '0);

  mac_ctrl #(.PASSES(PASSES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mul_is_zero(mul_is_zero),
    .load_run   (load_run),
    .load_zero  (load_zero),
    .step_en    (step_en),
    .busy       (busy),
    .last_pass  (last_pass),
    .done       (done)
  );

  mac_datapath #(.W(W), .STEPS(BITS_PER_PASS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_run (load_run),
    .load_zero(load_zero),
    .step_en  (step_en),
    .mcand    (mcand),
    .mplier   (mplier),
    .addend   (addend),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );
endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk #(
  parameter int W      = 16,
  parameter int PASSES = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] mcand,
  input logic [W-1:0] mplier,
  input logic [W-1:0] addend,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         done,
  input logic         busy
);
  logic [2*W-1:0] exp_q;
  int unsigned    run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q   <= '0;
      run_len <= 0;
    end else begin
      if (start && !busy)
        exp_q <= (2*W)'(mcand) * (2*W)'(mplier) + (2*W)'(addend);
      run_len <= busy ? run_len + 1 : 0;
    end
  end

  assert_result_value_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> ({res_hi, res_lo} == exp_q));

  assert_loop_length_R2: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (run_len == PASSES));

  assert_zero_shortcut_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mplier == '0) |=> (done && res_hi == '0 && res_lo == $past(addend)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $past(start)));

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo)));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (res_hi == '0 && res_lo == '0 && !done && !busy));
endmodule

bind mac_seq mac_seq_chk #(.W(W), .PASSES(PASSES)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .mcand (mcand),
  .mplier(mplier),
  .addend(addend),
  .res_hi(res_hi),
  .res_lo(res_lo),
  .done  (done),
  .busy  (busy)
);

// File: tb/sim_mac_seq.sv
`timescale 1ns/1ps
module sim_mac_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] mcand = '0, mplier = '0, addend = '0;
  logic [15:0] res_hi, res_lo;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  mac_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .mcand(mcand), .mplier(mplier), .addend(addend),
    .res_hi(res_hi), .res_lo(res_lo), .done(done)
  );

  function automatic logic [31:0] ref_mac(input logic [15:0] a, b, c);
    logic [31:0] acc;
    acc = {16'd0, c};
    for (int i = 0; i < 16; i++)
      if (b[i]) acc = acc + ({16'd0, a} << i);
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic run_op(input logic [15:0] a, b, c, input bit intrude);
    logic [31:0] exp_v;
    logic [31:0] held;
    int exp_lat;
    int lat;
    exp_v   = ref_mac(a, b, c);
    exp_lat = (b == 16'd0) ? 1 : 9;
    @(negedge clk);
    mcand = a; mplier = b; addend = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (intrude && lat == 3) begin
        start = 1'b1;
        mcand = ~a; mplier = 16'h1234; addend = 16'h4321;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (intrude) chk(lat == exp_lat, "R5 latency with mid-run start", lat, exp_lat);
    else if (b == 16'd0) chk(lat == exp_lat, "R3 zero latency", lat, exp_lat);
    else chk(lat == exp_lat, "R2 latency", lat, exp_lat);
    if (intrude) chk({res_hi, res_lo} == exp_v, "R5 result after mid-run start", {res_hi, res_lo}, exp_v);
    else if (b == 16'd0) chk({res_hi, res_lo} == {16'd0, c}, "R3 zero result", {res_hi, res_lo}, {16'd0, c});
    else chk({res_hi, res_lo} == exp_v, "R1 result", {res_hi, res_lo}, exp_v);
    held = {res_hi, res_lo};
    mcand = $urandom; mplier = $urandom; addend = $urandom;
    @(negedge clk);
    chk(done == 1'b0, "R4 single pulse", done, 0);
    @(negedge clk);
    mcand = $urandom; mplier = 16'd0; addend = $urandom;
    @(negedge clk);
    chk({res_hi, res_lo} == held, "R6 hold while idle", {res_hi, res_lo}, held);
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(res_hi == 16'd0 && res_lo == 16'd0, "R7 reset result", {res_hi, res_lo}, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    rst = 1'b0;

    run_op(16'd3, 16'd5, 16'd7, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);   // R8 extreme
    chk({res_hi, res_lo} == 32'hFFFF0000, "R8 all-ones", {res_hi, res_lo}, 32'hFFFF0000);
    run_op(16'd0, 16'hABCD, 16'h1357, 1'b0);      // R8 zero multiplicand
    chk({res_hi, res_lo} == 32'h00001357, "R8 zero multiplicand", {res_hi, res_lo}, 32'h00001357);
    run_op(16'h8001, 16'd0, 16'hBEEF, 1'b0);      // R3 shortcut
    run_op(16'h8000, 16'h8000, 16'd0, 1'b0);
    run_op(16'h5A5A, 16'h0001, 16'hFFFF, 1'b0);
    run_op(16'h1111, 16'h2222, 16'h3333, 1'b1);   // R5 ignored start
    run_op(16'hFFFF, 16'h8000, 16'h0001, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [15:0] ra, rb, rc;
      ra = $urandom; rb = $urandom; rc = $urandom;
      if (k % 9 == 0) rb = 16'd0;
      run_op(ra, rb, rc, (k % 7 == 3));
    end

    @(negedge clk);
    mcand = 16'h00FF; mplier = 16'h00FF; addend = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(res_hi == 16'd0 && res_lo == 16'd0 && !done, "R7 reset mid-run", {res_hi, res_lo}, 0);
    repeat (10) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 no done after reset", done, 0);
    end

    finish_run();
  end
endmodule